// File: doc/BRIEF.md
# Four-Way Write-Back Cache Directory

This block holds the tags and line state for a 16 KB, four-way set-associative, write-back cache with 16-byte lines. A lookup presents a physical address, a write flag and a byte-lane mask. One cycle later the block reports whether the address hit and in which way. On a write hit it marks as modified each 4-byte dword that the mask touches. On a miss it names a replacement way and returns that way's valid flag, old tag and modified-dword mask, so that surrounding logic can write back only the dwords that changed. The data array and the memory bus are outside this block.

A separate fill strobe installs a line after a miss. A debug port reads or writes one way's entry, together with the line's replacement bits, addressed by line number and way number. A global clear walks the directory one line per cycle. The same walk runs by itself after reset. The walk reports its progress on a busy flag, and while that flag is high all other inputs are ignored.

Top module: `cache_dir`

## Requirements
- R1: With the default parameters the line index is address bits [11:4] and the stored tag is bits [31:12]. A lookup hits only when a way at that index is valid and holds the same tag. One cycle after a lookup is accepted, rsp_valid is high for one cycle and carries rsp_hit and rsp_way. rsp_way is 0 on a miss.
- R2: A write hit sets dirty bit d of the hitting way (bit d of the 4-bit mask) when any of req_be[4d+3:4d] is set, and keeps all dirty bits that were already set. A read hit leaves the dirty bits unchanged.
- R3: A miss changes no state. If any way at that index is invalid, the victim is the lowest-numbered invalid way.
- R4: When all four ways are valid, the victim is chosen by the line's tree bits {b2,b1,b0}. If b0=0 the victim is way b1 (way 0 or 1). If b0=1 the victim is way 2+b2. On a miss the block reports vic_way, vic_valid, and the victim's tag and dirty mask. The tag and dirty mask read as zero when the victim is invalid. On a hit all victim outputs are zero.
- R5: Every lookup hit and every fill to way w updates the tree so that it points away from w. For w in {0,1}: b0=1 and b1=not w[0]. For w in {2,3}: b0=0 and b2=not w[0]. The bit of the other pair is left unchanged.
- R6: A fill writes the way that already holds its tag, if there is one. Otherwise it writes the victim way. It stores the tag, sets valid and clears all four dirty bits.
- R7: A debug read (dbg_en=1, dbg_we=0) returns the selected way's tag, valid bit and dirty bits, and the line's tree bits. The result appears with dbg_ack one cycle later.
- R8: A debug write (dbg_en=1, dbg_we=1) stores the given tag, valid bit and dirty bits into the selected way, and the given tree bits into the line. Later lookups use the stored values.
- R9: After reset, and after an inv_start pulse while idle, busy stays high for exactly 256 cycles (at default size). During that time every line is cleared: tag, valid bit and dirty bits of all four ways, and the line's tree bits.
- R10: While busy is high, lookups, fills and debug accesses are dropped. They raise neither rsp_valid nor dbg_ack and leave no trace in the directory.
- R11: When several operations are requested in the same cycle, a debug access goes first, then a fill, then a lookup. Only the first of these is performed; the others are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Lookup strobe |
| req_write | input | 1 | Lookup is a write |
| req_addr | input | 32 | Lookup physical address |
| req_be | input | 16 | Byte lanes written within the line |
| fill_valid | input | 1 | Install a line |
| fill_addr | input | 32 | Address of the line to install |
| inv_start | input | 1 | Start a global clear |
| busy | output | 1 | Clear walk in progress |
| rsp_valid | output | 1 | Lookup result valid |
| rsp_hit | output | 1 | Lookup hit |
| rsp_way | output | 2 | Hitting way |
| vic_valid | output | 1 | Victim held a valid line |
| vic_way | output | 2 | Victim way on a miss |
| vic_tag | output | 20 | Victim's old tag |
| vic_dirty | output | 4 | Victim's modified-dword mask |
| dbg_en | input | 1 | Debug access strobe |
| dbg_we | input | 1 | Debug access is a write |
| dbg_line | input | 8 | Debug line number |
| dbg_way | input | 2 | Debug way number |
| dbg_wtag | input | 20 | Tag to write |
| dbg_wvalid | input | 1 | Valid bit to write |
| dbg_wdirty | input | 4 | Dirty bits to write |
| dbg_wlru | input | 3 | Tree bits to write |
| dbg_ack | output | 1 | Debug read data valid |
| dbg_rtag | output | 20 | Tag read |
| dbg_rvalid | output | 1 | Valid bit read |
| dbg_rdirty | output | 4 | Dirty bits read |
| dbg_rlru | output | 3 | Tree bits read |

## Verification
The bench builds the block with its default parameters: 256 lines, 16-byte lines and 32-bit addresses. This means the full 20-bit tag compare and the real 256-cycle clear walk are exercised, both after reset and after a requested clear. At this size a single index can be filled to all four ways. This brings within reach the step from lowest-invalid victim selection to tree-based selection, and several victim rotations that check each branch of the tree. The debug port is used to preset lines, for example a line whose only valid way is way 0, so that victim choices other than way 0 can be reached quickly.

// File: rtl/cache_dir_pkg.sv
package cache_dir_pkg;

  localparam int NWAYS = 4;
  localparam int WAY_W = 2;

  typedef logic [2:0] plru_t;

  typedef enum logic [2:0] {
    OP_NONE,
    OP_CLEAR,
    OP_DBG_WR,
    OP_DBG_RD,
    OP_FILL,
    OP_LOOKUP
  } op_e;

  // Way the tree currently points at: b0 picks the pair, b1/b2 pick inside it.
  function automatic logic [WAY_W-1:0] plru_pick(plru_t t);
    if (t[0]) return t[2] ? 2'd3 : 2'd2;
    return t[1] ? 2'd1 : 2'd0;
  endfunction

  // Point the tree away from the way just used.
  function automatic plru_t plru_touch(plru_t t, logic [WAY_W-1:0] w);
    plru_t n;
    n = t;
    if (!w[1]) begin
      n[0] = 1'b1;
      n[1] = ~w[0];
    end else begin
      n[0] = 1'b0;
      n[2] = ~w[0];
    end
    return n;
  endfunction

endpackage

// File: rtl/cache_dir_way.sv
module cache_dir_way #(
  parameter int LINES  = 256,
  parameter int TAG_W  = 20,
  parameter int DWORDS = 4,
  localparam int IDX_W = $clog2(LINES),
  localparam int ENT_W = TAG_W + 1 + DWORDS
) (
  input  logic              clk,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [TAG_W-1:0]  rd_tag,
  output logic              rd_valid,
  output logic [DWORDS-1:0] rd_dirty,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [TAG_W-1:0]  wr_tag,
  input  logic              wr_valid,
  input  logic [DWORDS-1:0] wr_dirty
);

  // One entry per line: {tag, valid, dirty}; single write, asynchronous read.
  logic [ENT_W-1:0] mem [LINES];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_idx] <= {wr_tag, wr_valid, wr_dirty};
  end

  assign {rd_tag, rd_valid, rd_dirty} = mem[rd_idx];

endmodule

// File: rtl/cache_dir_lru.sv
module cache_dir_lru #(
  parameter int LINES  = 256,
  localparam int IDX_W = $clog2(LINES)
) (
  input  logic                      clk,
  input  logic [IDX_W-1:0]          rd_idx,
  output cache_dir_pkg::plru_t      rd_lru,
  input  logic                      wr_en,
  input  logic [IDX_W-1:0]          wr_idx,
  input  cache_dir_pkg::plru_t      wr_lru
);

  cache_dir_pkg::plru_t mem [LINES];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_idx] <= wr_lru;
  end

  assign rd_lru = mem[rd_idx];

endmodule

// File: rtl/cache_dir_sweep.sv
module cache_dir_sweep #(
  parameter int LINES  = 256,
  localparam int IDX_W = $clog2(LINES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  output logic             busy,
  output logic [IDX_W-1:0] idx
);

  localparam logic [IDX_W-1:0] LAST = IDX_W'(LINES - 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b1;
      idx  <= '0;
    end else if (busy) begin
      if (idx == LAST) begin
        busy <= 1'b0;
        idx  <= '0;
      end else begin
        idx <= idx + 1'b1;
      end
    end else if (start) begin
      busy <= 1'b1;
      idx  <= '0;
    end
  end

  // R9: a start request while idle always opens a walk
  p_start_busy_r9: assert property (@(posedge clk) disable iff (rst)
    (start && !busy) |=> busy);

  // R9: a walk leaves the last line only by finishing
  p_walk_ends_r9: assert property (@(posedge clk) disable iff (rst)
    (busy && idx == LAST) |=> (!busy && idx == '0));

endmodule

// File: rtl/cache_dir.sv
module cache_dir
  import cache_dir_pkg::*;
#(
  parameter int LINES      = 256,
  parameter int LINE_BYTES = 16,
  parameter int ADDR_W     = 32,
  localparam int OFF_W     = $clog2(LINE_BYTES),
  localparam int IDX_W     = $clog2(LINES),
  localparam int TAG_W     = ADDR_W - IDX_W - OFF_W,
  localparam int DWORDS    = LINE_BYTES / 4
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  req_valid,
  input  logic                  req_write,
  input  logic [ADDR_W-1:0]     req_addr,
  input  logic [LINE_BYTES-1:0] req_be,
  input  logic                  fill_valid,
  input  logic [ADDR_W-1:0]     fill_addr,
  input  logic                  inv_start,
  output logic                  busy,
  output logic                  rsp_valid,
  output logic                  rsp_hit,
  output logic [1:0]            rsp_way,
  output logic                  vic_valid,
  output logic [1:0]            vic_way,
  output logic [TAG_W-1:0]      vic_tag,
  output logic [DWORDS-1:0]     vic_dirty,
  input  logic                  dbg_en,
  input  logic                  dbg_we,
  input  logic [IDX_W-1:0]      dbg_line,
  input  logic [1:0]            dbg_way,
  input  logic [TAG_W-1:0]      dbg_wtag,
  input  logic                  dbg_wvalid,
  input  logic [DWORDS-1:0]     dbg_wdirty,
  input  logic [2:0]            dbg_wlru,
  output logic                  dbg_ack,
  output logic [TAG_W-1:0]      dbg_rtag,
  output logic                  dbg_rvalid,
  output logic [DWORDS-1:0]     dbg_rdirty,
  output logic [2:0]            dbg_rlru
);

  // ---------------------------------------------------------------- operation select
  op_e              op;
  logic [IDX_W-1:0] sweep_idx;
  logic [IDX_W-1:0] idx;
  logic [TAG_W-1:0] look_tag;
  logic             unused_bits;

  always_comb begin
    if (busy)                 op = OP_CLEAR;
    else if (dbg_en && dbg_we) op = OP_DBG_WR;
    else if (dbg_en)          op = OP_DBG_RD;
    else if (fill_valid)      op = OP_FILL;
    else if (req_valid)       op = OP_LOOKUP;
    else                      op = OP_NONE;
  end

  always_comb begin
    unique case (op)
      OP_CLEAR:             idx = sweep_idx;
      OP_DBG_WR, OP_DBG_RD: idx = dbg_line;
      OP_FILL:              idx = fill_addr[OFF_W +: IDX_W];
      default:              idx = req_addr[OFF_W +: IDX_W];
    endcase
  end

  assign look_tag    = (op == OP_FILL) ? fill_addr[ADDR_W-1 -: TAG_W]
                                       : req_addr[ADDR_W-1 -: TAG_W];
  assign unused_bits = ^{req_addr[OFF_W-1:0], fill_addr[OFF_W-1:0]};

  cache_dir_sweep #(.LINES(LINES)) u_sweep (
    .clk   (clk),
    .rst   (rst),
    .start (inv_start),
    .busy  (busy),
    .idx   (sweep_idx)
  );

  // ---------------------------------------------------------------- storage
  logic [TAG_W-1:0]  rd_tag   [NWAYS];
  logic [NWAYS-1:0]  rd_valid;
  logic [DWORDS-1:0] rd_dirty [NWAYS];
  logic [NWAYS-1:0]  w_en;
  logic [TAG_W-1:0]  w_tag    [NWAYS];
  logic [NWAYS-1:0]  w_val;
  logic [DWORDS-1:0] w_dirty  [NWAYS];
  plru_t             rd_lru, lru_wd;
  logic              lru_we;

  for (genvar w = 0; w < NWAYS; w++) begin : g_way
    cache_dir_way #(.LINES(LINES), .TAG_W(TAG_W), .DWORDS(DWORDS)) u_way (
      .clk      (clk),
      .rd_idx   (idx),
      .rd_tag   (rd_tag[w]),
      .rd_valid (rd_valid[w]),
      .rd_dirty (rd_dirty[w]),
      .wr_en    (w_en[w]),
      .wr_idx   (idx),
      .wr_tag   (w_tag[w]),
      .wr_valid (w_val[w]),
      .wr_dirty (w_dirty[w])
    );
  end

  cache_dir_lru #(.LINES(LINES)) u_lru (
    .clk    (clk),
    .rd_idx (idx),
    .rd_lru (rd_lru),
    .wr_en  (lru_we),
    .wr_idx (idx),
    .wr_lru (lru_wd)
  );

  // ---------------------------------------------------------------- compare and choose
  logic [NWAYS-1:0]  hit_vec;
  logic              hit_any;
  logic [1:0]        hit_way, inv_way, victim, alloc;
  logic [DWORDS-1:0] dmask;

  for (genvar w = 0; w < NWAYS; w++) begin : g_cmp
    assign hit_vec[w] = rd_valid[w] && (rd_tag[w] == look_tag);
  end

  for (genvar d = 0; d < DWORDS; d++) begin : g_dw
    assign dmask[d] = |req_be[4*d +: 4];
  end

  always_comb begin
    hit_way = '0;
    inv_way = '0;
    for (int w = NWAYS - 1; w >= 0; w--) begin
      if (hit_vec[w])   hit_way = 2'(w);
      if (!rd_valid[w]) inv_way = 2'(w);
    end
  end

  assign hit_any = |hit_vec;
  assign victim  = (~&rd_valid) ? inv_way : plru_pick(rd_lru);
  assign alloc   = hit_any ? hit_way : victim;

  // ---------------------------------------------------------------- update
  always_comb begin
    for (int w = 0; w < NWAYS; w++) begin
      w_en[w]    = 1'b0;
      w_tag[w]   = rd_tag[w];
      w_val[w]   = rd_valid[w];
      w_dirty[w] = rd_dirty[w];
    end
    lru_we = 1'b0;
    lru_wd = rd_lru;
    unique case (op)
      OP_CLEAR: begin
        for (int w = 0; w < NWAYS; w++) begin
          w_en[w]    = 1'b1;
          w_tag[w]   = '0;
          w_val[w]   = 1'b0;
          w_dirty[w] = '0;
        end
        lru_we = 1'b1;
        lru_wd = '0;
      end
      OP_DBG_WR: begin
        w_en[dbg_way]    = 1'b1;
        w_tag[dbg_way]   = dbg_wtag;
        w_val[dbg_way]   = dbg_wvalid;
        w_dirty[dbg_way] = dbg_wdirty;
        lru_we = 1'b1;
        lru_wd = dbg_wlru;
      end
      OP_FILL: begin
        w_en[alloc]    = 1'b1;
        w_tag[alloc]   = look_tag;
        w_val[alloc]   = 1'b1;
        w_dirty[alloc] = '0;
        lru_we = 1'b1;
        lru_wd = plru_touch(rd_lru, alloc);
      end
      OP_LOOKUP: begin
        if (hit_any) begin
          w_en[hit_way]    = 1'b1;
          w_dirty[hit_way] = rd_dirty[hit_way] | (req_write ? dmask : '0);
          lru_we = 1'b1;
          lru_wd = plru_touch(rd_lru, hit_way);
        end
      end
      default: ;
    endcase
  end

  // ---------------------------------------------------------------- registered outputs
  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid  <= 1'b0;
      rsp_hit    <= 1'b0;
      rsp_way    <= '0;
      vic_valid  <= 1'b0;
      vic_way    <= '0;
      vic_tag    <= '0;
      vic_dirty  <= '0;
      dbg_ack    <= 1'b0;
      dbg_rtag   <= '0;
      dbg_rvalid <= 1'b0;
      dbg_rdirty <= '0;
      dbg_rlru   <= '0;
    end else begin
      rsp_valid <= (op == OP_LOOKUP);
      dbg_ack   <= (op == OP_DBG_RD);
      if (op == OP_LOOKUP) begin
        rsp_hit   <= hit_any;
        rsp_way   <= hit_any ? hit_way : '0;
        vic_way   <= hit_any ? '0 : victim;
        vic_valid <= !hit_any && rd_valid[victim];
        vic_tag   <= (!hit_any && rd_valid[victim]) ? rd_tag[victim] : '0;
        vic_dirty <= (!hit_any && rd_valid[victim]) ? rd_dirty[victim] : '0;
      end
      if (op == OP_DBG_RD) begin
        dbg_rtag   <= rd_tag[dbg_way];
        dbg_rvalid <= rd_valid[dbg_way];
        dbg_rdirty <= rd_dirty[dbg_way];
        dbg_rlru   <= rd_lru;
      end
    end
  end

  // ---------------------------------------------------------------- assertions
  // R1: a result only follows a lookup request
  p_rsp_follows_req_r1: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> $past(req_valid));

  // R1: tags at one index never match in two ways during a lookup
  p_single_hit_r1: assert property (@(posedge clk) disable iff (rst)
    (op == OP_LOOKUP) |-> $onehot0(hit_vec));

  // R4: a hit carries no victim information
  p_hit_no_victim_r4: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_hit) |-> (!vic_valid && vic_dirty == '0 && vic_way == '0));

  // R10: nothing is answered in the cycle after a busy cycle
  p_quiet_when_busy_r10: assert property (@(posedge clk) disable iff (rst)
    $past(busy) |-> (!rsp_valid && !dbg_ack));

  // R7: debug data follows a debug read request
  p_dbg_follows_rd_r7: assert property (@(posedge clk) disable iff (rst)
    dbg_ack |-> $past(dbg_en && !dbg_we));

endmodule

// File: tb/cache_dir_bench.sv
`timescale 1ns/100ps
module cache_dir_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 0, req_write = 0;
  logic [31:0] req_addr = '0;
  logic [15:0] req_be = '0;
  logic        fill_valid = 0;
  logic [31:0] fill_addr = '0;
  logic        inv_start = 0;
  logic        busy, rsp_valid, rsp_hit, vic_valid;
  logic [1:0]  rsp_way, vic_way;
  logic [19:0] vic_tag;
  logic [3:0]  vic_dirty;
  logic        dbg_en = 0, dbg_we = 0;
  logic [7:0]  dbg_line = '0;
  logic [1:0]  dbg_way = '0;
  logic [19:0] dbg_wtag = '0;
  logic        dbg_wvalid = 0;
  logic [3:0]  dbg_wdirty = '0;
  logic [2:0]  dbg_wlru = '0;
  logic        dbg_ack, dbg_rvalid;
  logic [19:0] dbg_rtag;
  logic [3:0]  dbg_rdirty;
  logic [2:0]  dbg_rlru;

  always #2.5 clk = ~clk;

  cache_dir u_cache_dir (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr), .req_be(req_be),
    .fill_valid(fill_valid), .fill_addr(fill_addr), .inv_start(inv_start), .busy(busy),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_way(rsp_way),
    .vic_valid(vic_valid), .vic_way(vic_way), .vic_tag(vic_tag), .vic_dirty(vic_dirty),
    .dbg_en(dbg_en), .dbg_we(dbg_we), .dbg_line(dbg_line), .dbg_way(dbg_way),
    .dbg_wtag(dbg_wtag), .dbg_wvalid(dbg_wvalid), .dbg_wdirty(dbg_wdirty), .dbg_wlru(dbg_wlru),
    .dbg_ack(dbg_ack), .dbg_rtag(dbg_rtag), .dbg_rvalid(dbg_rvalid),
    .dbg_rdirty(dbg_rdirty), .dbg_rlru(dbg_rlru)
  );

  int checks = 0;
  int failures = 0;
  bit done = 0;

  // expected lookup result {hit, way, vvalid, vway, vtag, vdirty}
  typedef struct packed {
    logic        hit;
    logic [1:0]  way;
    logic        vv;
    logic [1:0]  vway;
    logic [19:0] vtag;
    logic [3:0]  vd;
  } rsp_exp_t;
  typedef struct packed {
    logic [19:0] tag;
    logic        v;
    logic [3:0]  d;
    logic [2:0]  lru;
  } dbg_exp_t;

  rsp_exp_t rsp_q[$];
  string    rsp_r[$];
  dbg_exp_t dbg_q[$];
  string    dbg_r[$];

  task automatic check(input bit ok, input string r, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", r, what, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(input logic [19:0] tag, input logic [7:0] line);
    return {tag, line, 4'h0};
  endfunction

  // ---------------------------------------------------------------- monitor
  always @(negedge clk) begin
    if (!rst && !done) begin
      if (rsp_valid) begin
        if (rsp_q.size() == 0) check(1'b0, "R10/R11", "unexpected lookup result", 32'd1, 32'd0);
        else begin
          rsp_exp_t e;
          string r;
          e = rsp_q.pop_front();
          r = rsp_r.pop_front();
          check(rsp_hit == e.hit,    r, "hit",       32'(rsp_hit),   32'(e.hit));
          check(rsp_way == e.way,    r, "way",       32'(rsp_way),   32'(e.way));
          check(vic_valid == e.vv,   r, "vic_valid", 32'(vic_valid), 32'(e.vv));
          check(vic_way == e.vway,   r, "vic_way",   32'(vic_way),   32'(e.vway));
          check(vic_tag == e.vtag,   r, "vic_tag",   32'(vic_tag),   32'(e.vtag));
          check(vic_dirty == e.vd,   r, "vic_dirty", 32'(vic_dirty), 32'(e.vd));
        end
      end
      if (dbg_ack) begin
        if (dbg_q.size() == 0) check(1'b0, "R10", "unexpected debug data", 32'd1, 32'd0);
        else begin
          dbg_exp_t e;
          string r;
          e = dbg_q.pop_front();
          r = dbg_r.pop_front();
          check(dbg_rtag == e.tag,   r, "dbg tag",   32'(dbg_rtag),   32'(e.tag));
          check(dbg_rvalid == e.v,   r, "dbg valid", 32'(dbg_rvalid), 32'(e.v));
          check(dbg_rdirty == e.d,   r, "dbg dirty", 32'(dbg_rdirty), 32'(e.d));
          check(dbg_rlru == e.lru,   r, "dbg lru",   32'(dbg_rlru),   32'(e.lru));
        end
      end
    end
  end

  // ---------------------------------------------------------------- drivers
  task automatic lookup(input logic [19:0] tag, input logic [7:0] line, input logic we,
                        input logic [15:0] be, input logic ehit, input logic [1:0] eway,
                        input logic evv, input logic [1:0] evway, input logic [19:0] evtag,
                        input logic [3:0] evd, input string r);
    rsp_q.push_back('{ehit, eway, evv, evway, evtag, evd});
    rsp_r.push_back(r);
    req_valid = 1; req_write = we; req_addr = mk(tag, line); req_be = be;
    @(negedge clk);
    req_valid = 0; req_write = 0;
  endtask

  task automatic fill(input logic [19:0] tag, input logic [7:0] line);
    fill_valid = 1; fill_addr = mk(tag, line);
    @(negedge clk);
    fill_valid = 0;
  endtask

  task automatic dbg_read(input logic [7:0] line, input logic [1:0] way,
                          input logic [19:0] etag, input logic ev, input logic [3:0] ed,
                          input logic [2:0] elru, input string r);
    dbg_q.push_back('{etag, ev, ed, elru});
    dbg_r.push_back(r);
    dbg_en = 1; dbg_we = 0; dbg_line = line; dbg_way = way;
    @(negedge clk);
    dbg_en = 0;
  endtask

  task automatic dbg_write(input logic [7:0] line, input logic [1:0] way, input logic [19:0] tag,
                           input logic v, input logic [3:0] d, input logic [2:0] lru);
    dbg_en = 1; dbg_we = 1; dbg_line = line; dbg_way = way;
    dbg_wtag = tag; dbg_wvalid = v; dbg_wdirty = d; dbg_wlru = lru;
    @(negedge clk);
    dbg_en = 0; dbg_we = 0;
  endtask

  task automatic finish_run();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  // ---------------------------------------------------------------- watchdog
  initial begin
    repeat (50000) @(posedge clk);
    check(1'b0, "watchdog", "run did not end", 32'd1, 32'd0);
    finish_run();
  end

  // ---------------------------------------------------------------- stimulus
  initial begin
    int n;
    repeat (3) @(negedge clk);
    rst = 0;
    // R9: reset state and automatic clear walk
    check(busy == 1'b1, "R9", "busy after reset", 32'(busy), 32'd1);
    check(rsp_valid == 1'b0 && dbg_ack == 1'b0, "R9", "outputs idle after reset",
          32'({rsp_valid, dbg_ack}), 32'd0);
    n = 0;
    while (busy && n < 1000) begin n++; @(negedge clk); end
    check(n == 256, "R9", "busy cycles after reset", 32'(n), 32'd256);

    // R3: empty line misses with way 0 as victim
    lookup(20'h12345, 8'h05, 0, 16'h0000, 0, 2'd0, 0, 2'd0, 20'h0, 4'h0, "R3");
    fill(20'h12345, 8'h05);
    // R1 R2: write hit on way 0 touching bytes 4 and 5 only
    lookup(20'h12345, 8'h05, 1, 16'h0030, 1, 2'd0, 0, 2'd0, 20'h0, 4'h0, "R1");
    dbg_read(8'h05, 2'd0, 20'h12345, 1, 4'b0010, 3'b011, "R2");
    // R2: read hit keeps dirty bits
    lookup(20'h12345, 8'h05, 0, 16'hFFFF, 1, 2'd0, 0, 2'd0, 20'h0, 4'h0, "R2");
    dbg_read(8'h05, 2'd0, 20'h12345, 1, 4'b0010, 3'b011, "R2");
    // fill remaining ways of line 5, tree ends at 000
    fill(20'h0AAAA, 8'h05);
    fill(20'h0BBBB, 8'h05);
    fill(20'h0CCCC, 8'h05);
    lookup(20'h0CCCC, 8'h05, 1, 16'hF001, 1, 2'd3, 0, 2'd0, 20'h0, 4'h0, "R1");
    dbg_read(8'h05, 2'd3, 20'h0CCCC, 1, 4'b1001, 3'b000, "R2");
    // R4: full line, tree 000 points at way 0
    lookup(20'h0DDDD, 8'h05, 0, 16'h0, 0, 2'd0, 1, 2'd0, 20'h12345, 4'b0010, "R4");
    // R5: hit on way 1 turns tree to 001, victim becomes way 2
    lookup(20'h0AAAA, 8'h05, 0, 16'h0, 1, 2'd1, 0, 2'd0, 20'h0, 4'h0, "R5");
    lookup(20'h0DDDD, 8'h05, 0, 16'h0, 0, 2'd0, 1, 2'd2, 20'h0BBBB, 4'b0000, "R5");
    // R6: fill replaces way 2, tree 100, victim way 0
    fill(20'h0DDDD, 8'h05);
    lookup(20'h0EEEE, 8'h05, 0, 16'h0, 0, 2'd0, 1, 2'd0, 20'h12345, 4'b0010, "R6");
    dbg_read(8'h05, 2'd2, 20'h0DDDD, 1, 4'b0000, 3'b100, "R6");
    // R6: refill of a present tag reuses its way and clears dirty
    fill(20'h0CCCC, 8'h05);
    dbg_read(8'h05, 2'd3, 20'h0CCCC, 1, 4'b0000, 3'b000, "R6");
    dbg_read(8'h05, 2'd1, 20'h0AAAA, 1, 4'b0000, 3'b000, "R6");

    // R8: debug-written entry is found by lookups
    dbg_write(8'h20, 2'd1, 20'h54321, 1, 4'b1111, 3'b110);
    lookup(20'h54321, 8'h20, 0, 16'h0, 1, 2'd1, 0, 2'd0, 20'h0, 4'h0, "R8");
    dbg_read(8'h20, 2'd1, 20'h54321, 1, 4'b1111, 3'b101, "R8");
    lookup(20'h00777, 8'h20, 0, 16'h0, 0, 2'd0, 0, 2'd0, 20'h0, 4'h0, "R3");
    // R3: lowest invalid way other than 0
    dbg_write(8'h21, 2'd0, 20'h00001, 1, 4'b0000, 3'b000);
    lookup(20'h00002, 8'h21, 0, 16'h0, 0, 2'd0, 0, 2'd1, 20'h0, 4'h0, "R3");

    // R11: debug read beats fill; fill is dropped
    dbg_q.push_back('{20'h12345, 1'b1, 4'b0010, 3'b000});
    dbg_r.push_back("R11");
    dbg_en = 1; dbg_we = 0; dbg_line = 8'h05; dbg_way = 2'd0;
    fill_valid = 1; fill_addr = mk(20'h77777, 8'h30);
    req_valid = 1; req_addr = mk(20'h12345, 8'h05);
    @(negedge clk);
    dbg_en = 0; fill_valid = 0; req_valid = 0;
    lookup(20'h77777, 8'h30, 0, 16'h0, 0, 2'd0, 0, 2'd0, 20'h0, 4'h0, "R11");
    // R11: fill beats lookup; lookup gives no result
    fill_valid = 1; fill_addr = mk(20'h77777, 8'h30);
    req_valid = 1; req_addr = mk(20'h77777, 8'h30);
    @(negedge clk);
    fill_valid = 0; req_valid = 0;
    @(negedge clk);
    lookup(20'h77777, 8'h30, 0, 16'h0, 1, 2'd0, 0, 2'd0, 20'h0, 4'h0, "R11");

    // R9 R10: requested clear; traffic during the walk is dropped
    inv_start = 1;
    @(negedge clk);
    inv_start = 0;
    check(busy == 1'b1, "R9", "busy after start", 32'(busy), 32'd1);
    n = 0;
    while (busy && n < 1000) begin
      if (n == 5) begin
        req_valid = 1; req_addr = mk(20'h12345, 8'h05);
      end
      if (n == 6) begin
        req_valid = 0;
        dbg_en = 1; dbg_we = 1; dbg_line = 8'h40; dbg_way = 2'd2;
        dbg_wtag = 20'hABCDE; dbg_wvalid = 1; dbg_wdirty = 4'hF; dbg_wlru = 3'b111;
      end
      if (n == 7) begin
        dbg_en = 0; dbg_we = 0;
        fill_valid = 1; fill_addr = mk(20'h22222, 8'h50);
      end
      if (n == 8) fill_valid = 0;
      n++;
      @(negedge clk);
    end
    check(n == 256, "R9", "busy cycles after start", 32'(n), 32'd256);
    dbg_read(8'h05, 2'd0, 20'h0, 0, 4'b0000, 3'b000, "R9");
    dbg_read(8'h20, 2'd1, 20'h0, 0, 4'b0000, 3'b000, "R9");
    dbg_read(8'h40, 2'd2, 20'h0, 0, 4'b0000, 3'b000, "R10");
    lookup(20'h22222, 8'h50, 0, 16'h0, 0, 2'd0, 0, 2'd0, 20'h0, 4'h0, "R10");
    lookup(20'h12345, 8'h05, 0, 16'h0, 0, 2'd0, 0, 2'd0, 20'h0, 4'h0, "R9");

    repeat (3) @(negedge clk);
    check(rsp_q.size() == 0, "R1", "lookup results missing", 32'(rsp_q.size()), 32'd0);
    check(dbg_q.size() == 0, "R7", "debug results missing", 32'(dbg_q.size()), 32'd0);
    finish_run();
  end

endmodule